// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Interface

This block is the digital front end of an 8-bit voltage-output converter driven from a microprocessor-style parallel bus. A host writes through a data byte and five active-low strobes: select, write, load, clear and power-down. A fast local clock samples these strobes, and edge detectors built from the sampled copies decide when a write finishes and when a load pulse arrives. Two registers sit behind the bus: a staging register that captures each written byte, and an output register that feeds the converter. The output register's 8-bit code is split into two 4-bit halves. Each half drives a 15-line thermometer code for a segmented current-source array.

The load strobe's level at the end of a write chooses the update style. If it is low, the output follows the write at once. If it is high, the output waits for the next falling edge of the load strobe, so several converters can change together. Clear zeroes the output asynchronously. Power-down raises a flag and leaves all stored data alone. After reset, the staging register is zero and the output register tracks it transparently. The first completed write therefore reaches the output directly, and double buffering applies from then on.

Top module: `pdac_core`

## Requirements
- R1: A write is active only while `cs_n` and `wr_n` are both low. The staging register takes the byte that was on `din` before the first of the two strobes rose. A change of `din` at the same moment as that rising strobe is not captured. The output code follows a completed write no later than 3 clock edges after the ending strobe rises.
- R2: If `ldac_n` is low when a write completes, the output register loads the written byte at the same time as the staging register.
- R3: If `ldac_n` is high when a write completes (after the first write), the output code keeps its previous value. A later falling edge of `ldac_n` copies the staging register into the output register.
- R4: Suppose a write completes with `ldac_n` high, and `ldac_n` then falls and stays low. If a new write starts while `ldac_n` is still low, `proto_err` pulses high for exactly one cycle. A write started under plain automatic update (load strobe held low, with no pending transfer) raises no flag.
- R5: While `clr_n` is low, `code` is zero with no clock delay, and the output register is loaded with zero. After `clr_n` is released, `code` stays zero. The staging register is not affected, so a later load pulse restores the byte written before the clear.
- R6: When a clear and an output-register update fall in the same clock cycle, the clear wins and the output register ends at zero.
- R7: After reset, `code` is 0. The first completed write appears on `code` whatever the level of `ldac_n`. Double buffering applies only after that write.
- R8: `pwr_down` is 1 while `pd_n` is low (after synchronization) and 0 otherwise. Entering or leaving power-down changes neither register.
- R9: `therm_hi` decodes `code[7:4]` and `therm_lo` decodes `code[3:0]`. Bit i of each is 1 exactly when that nibble is greater than i (bit 0 is the least significant).
- R10: A `wr_n` pulse while `cs_n` is high writes nothing.
- R11: The following are outside the operating envelope and are flagged at the pins:
  - a low pulse on `wr_n`, `ldac_n` or `clr_n` shorter than 2 clock cycles;
  - `din` stable for less than 2 cycles before a write starts;
  - a falling edge of `ldac_n` less than 2 cycles after `wr_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and registers |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ldac_n | input | 1 | Load strobe, active low; also picks the update mode at write end |
| clr_n | input | 1 | Asynchronous clear of the output code, active low |
| pd_n | input | 1 | Power-down request, active low |
| din | input | 8 | Parallel data byte |
| code | output | 8 | Output register code, straight binary |
| pwr_down | output | 1 | Power-down flag |
| proto_err | output | 1 | One-cycle pulse on a write started while load is still held low after a synchronous transfer |
| therm_hi | output | 15 | Thermometer code of the upper nibble |
| therm_lo | output | 15 | Thermometer code of the lower nibble |

## Verification
A wrong update-mode decision shows up on `code` within three clock edges of the write ending. Either the output changes when it should hold, or it holds when it should follow. A corrupted staging register stays hidden until the next load pulse, so every clear and power-down scenario ends with a load pulse that brings the staged byte out to the pins. A wrong pending-transfer flag shows up only as a missing or spurious `proto_err` pulse at the start of the following write.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  // Whether a completed write still owes the output register a transfer
  typedef enum logic {
    UPD_AUTO = 1'b0,
    UPD_SYNC = 1'b1
  } upd_mode_e;

  function automatic logic went_low(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic went_high(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pdac_therm.sv
module pdac_therm #(
  parameter int NIB_W = 4,
  localparam int TH_W = (1 << NIB_W) - 1
) (
  input  logic [NIB_W-1:0] nib,
  output logic [TH_W-1:0]  th
);

  for (genvar i = 0; i < TH_W; i++) begin : g_seg
    assign th[i] = (32'(nib) > i);
  end

  always_comb begin
    if (!$isunknown(nib)) begin
      AST_THERM_COUNT: assert ($countones(th) == 32'(nib)); // R9
      AST_THERM_SHAPE: assert ((th & (th + 1'b1)) == '0); // R9
    end
  end

endmodule

// File: rtl/pdac_regs.sv
module pdac_regs
  import pdac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_cs_n,
  input  logic              s_wr_n,
  input  logic              s_ldac_n,
  input  logic              s_clr_n,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q,
  output logic              wr_done,
  output logic              ldac_fall,
  output logic              por_active,
  output logic              proto_err
);

  logic      s_write;
  logic      p_write;
  logic      p_ldac_n;
  logic      wr_start;
  logic      ldac_rise;
  logic      lock;
  upd_mode_e pend;

  assign s_write   = ~s_cs_n & ~s_wr_n;
  assign wr_start  = went_high(p_write, s_write);
  assign wr_done   = went_low(p_write, s_write);
  assign ldac_fall = went_low(p_ldac_n, s_ldac_n);
  assign ldac_rise = went_high(p_ldac_n, s_ldac_n);

  // edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_write  <= 1'b0;
      p_ldac_n <= 1'b1;
    end else begin
      p_write  <= s_write;
      p_ldac_n <= s_ldac_n;
    end
  end

  // staging register: clear never touches it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_q <= '0;
    else if (wr_done) in_q <= cap_data;
  end

  // output register with clear priority and power-on transparency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dac_q <= '0;
    else if (!s_clr_n)                dac_q <= '0;
    else if (por_active)              dac_q <= wr_done ? cap_data : in_q;
    else if (wr_done && !s_ldac_n)    dac_q <= cap_data;
    else if (ldac_fall)               dac_q <= in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       por_active <= 1'b1;
    else if (wr_done) por_active <= 1'b0;
  end

  // pending synchronous transfer and load-held-low lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= UPD_AUTO;
      lock      <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= wr_start & lock;
      if (wr_done)        pend <= (s_ldac_n && !por_active) ? UPD_SYNC : UPD_AUTO;
      else if (ldac_fall) pend <= UPD_AUTO;
      if (ldac_fall && pend == UPD_SYNC) lock <= 1'b1;
      else if (ldac_rise)                lock <= 1'b0;
    end
  end

  AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !s_ldac_n && s_clr_n) |=> dac_q == $past(cap_data)); // R2
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && s_ldac_n && s_clr_n && !por_active) |=> $stable(dac_q)); // R3
  AST_LDAC_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !wr_done && s_clr_n && !por_active) |=> dac_q == $past(in_q)); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_clr_n) |=> dac_q == '0); // R6
  AST_CLR_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_clr_n && !wr_done) |=> $stable(in_q)); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err); // R4
  AST_POR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (in_q == '0 && dac_q == '0)); // R7
  AST_POR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (por_active && wr_done && s_clr_n) |=> dac_q == $past(cap_data)); // R7

endmodule

// File: rtl/pdac_core.sv
module pdac_core #(
  parameter int  DATA_W      = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int NIB_W       = DATA_W / 2,
  localparam int TH_W        = (1 << NIB_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              pd_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code,
  output logic              pwr_down,
  output logic              proto_err,
  output logic [TH_W-1:0]   therm_hi,
  output logic [TH_W-1:0]   therm_lo
);

  localparam int NSTRB = 5;

  logic [NSTRB-1:0]  strb_raw;
  logic [NSTRB-1:0]  strb_s;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] dac_q;
  logic              s_cs_n, s_wr_n, s_ldac_n, s_clr_n, s_pd_n;
  logic              wr_done, ldac_fall, por_active;

  assign strb_raw = {cs_n, wr_n, ldac_n, clr_n, pd_n};
  assign {s_cs_n, s_wr_n, s_ldac_n, s_clr_n, s_pd_n} = strb_s;

  pdac_sync #(.WIDTH(NSTRB), .STAGES(SYNC_STAGES), .RST_VAL({NSTRB{1'b1}})) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
  );

  // data delayed one stage beyond the strobes: value held before write end
  pdac_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES + 1), .RST_VAL('0)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d(din), .q(cap_data)
  );

  pdac_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(s_cs_n), .s_wr_n(s_wr_n), .s_ldac_n(s_ldac_n), .s_clr_n(s_clr_n),
    .cap_data(cap_data), .in_q(in_q), .dac_q(dac_q),
    .wr_done(wr_done), .ldac_fall(ldac_fall), .por_active(por_active),
    .proto_err(proto_err)
  );

  // pin-level clear acts at once; the sampled copy covers until the register is zero
  assign code     = (clr_n && s_clr_n) ? dac_q : '0;
  assign pwr_down = ~s_pd_n;

  pdac_therm #(.NIB_W(NIB_W)) u_therm_hi (.nib(code[DATA_W-1:NIB_W]), .th(therm_hi));
  pdac_therm #(.NIB_W(NIB_W)) u_therm_lo (.nib(code[NIB_W-1:0]),      .th(therm_lo));

  AST_PD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pwr_down) && !wr_done && !ldac_fall && s_clr_n) |=> $stable(dac_q)); // R8
  AST_PD_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pwr_down) && !wr_done) |=> $stable(in_q)); // R8
  AST_POR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (por_active && clr_n) |-> code == '0); // R7

endmodule

// File: tb/pdac_core_bench.sv
module pdac_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_CYC    = 2;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_n, ldac_n, clr_n, pd_n;
  logic [7:0]  din;
  logic [7:0]  code;
  logic        pwr_down, proto_err;
  logic [14:0] therm_hi, therm_lo;

  int total = 0;
  int bad   = 0;
  int err_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdac_core u_pdac_core (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
    .clr_n(clr_n), .pd_n(pd_n), .din(din), .code(code), .pwr_down(pwr_down),
    .proto_err(proto_err), .therm_hi(therm_hi), .therm_lo(therm_lo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] ref_therm(input logic [3:0] n);
    return 15'((32'd1 << n) - 1);
  endfunction

  task automatic check_code(input string req, input logic [7:0] exp);
    check(req, code, exp);
    check({req, " R9 hi"}, therm_hi, ref_therm(exp[7:4]));
    check({req, " R9 lo"}, therm_lo, ref_therm(exp[3:0]));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---- timing envelope monitors (R11) ----
  int   wr_low = 0, ldac_low = 0, clr_low = 0;
  int   din_stable = 0, since_wr_rise = 1000;
  logic [7:0] din_prev = 8'h00;
  logic wact_prev = 1'b0, wr_prev = 1'b1, ldac_prev = 1'b1;

  always @(posedge clk) begin
    if (rst_n === 1'b1) begin
      if (!wr_n) wr_low++;
      else begin
        if (wr_low != 0) check("R11 wr width", (wr_low >= MIN_CYC), 1);
        wr_low = 0;
      end
      if (!ldac_n) ldac_low++;
      else begin
        if (ldac_low != 0) check("R11 ldac width", (ldac_low >= MIN_CYC), 1);
        ldac_low = 0;
      end
      if (!clr_n) clr_low++;
      else begin
        if (clr_low != 0) check("R11 clr width", (clr_low >= MIN_CYC), 1);
        clr_low = 0;
      end
      din_stable = (din === din_prev) ? din_stable + 1 : 0;
      if (!cs_n && !wr_n && !wact_prev) check("R11 data setup", (din_stable >= MIN_CYC), 1);
      if (wr_n && !wr_prev) since_wr_rise = 0;
      else if (since_wr_rise < 1000) since_wr_rise++;
      if (!ldac_n && ldac_prev) check("R11 wr-to-ldac setup", (since_wr_rise >= MIN_CYC), 1);
      if (proto_err === 1'b1) err_seen++;
    end
    din_prev  = din;
    wact_prev = !cs_n && !wr_n;
    wr_prev   = wr_n;
    ldac_prev = ldac_n;
  end

  // ---- stimulus helpers ----
  task automatic do_write(input logic [7:0] d, input bit cs_first);
    @(negedge clk) din = d;
    cyc(3);
    cs_n = 1'b0; wr_n = 1'b0;
    cyc(3);
    if (cs_first) begin cs_n = 1'b1; din = ~d; cyc(1); wr_n = 1'b1; end
    else          begin wr_n = 1'b1; din = ~d; cyc(1); cs_n = 1'b1; end
    cyc(5);
  endtask

  task automatic wr_only(input logic [7:0] d);
    @(negedge clk) din = d;
    cyc(3); wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(5);
  endtask

  task automatic pulse_ldac();
    @(negedge clk) ldac_n = 1'b0;
    cyc(3); ldac_n = 1'b1; cyc(5);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check_code("R7 reset code", 8'h00);
    check("R8 reset pd flag", pwr_down, 0);
    check("R4 reset err", proto_err, 0);
  endtask

  task automatic t_por();
    do_write(8'hA5, 0);
    check_code("R7 first write transparent", 8'hA5);
    do_write(8'h3C, 0);
    check_code("R3 sync hold", 8'hA5);
    pulse_ldac();
    check_code("R3 ldac transfer", 8'h3C);
  endtask

  task automatic t_auto();
    int e0;
    e0 = err_seen;
    @(negedge clk) ldac_n = 1'b0;
    cyc(3);
    do_write(8'h5A, 0);
    check_code("R2 auto update", 8'h5A);
    do_write(8'hC3, 1);
    check_code("R1 cs-first end, hold", 8'hC3);
    wr_only(8'h77);
    check_code("R10 wr without cs ignored", 8'hC3);
    check("R4 no flag in auto", err_seen - e0, 0);
  endtask

  task automatic t_therm();
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h80, 8'h0F, 8'h96};
    foreach (pats[i]) begin
      do_write(pats[i], 0);
      check_code("R9 thermometer", pats[i]);
    end
    @(negedge clk) ldac_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_proto();
    int e0;
    do_write(8'h11, 0);
    check_code("R3 sync hold before proto", 8'h96);
    e0 = err_seen;
    @(negedge clk) ldac_n = 1'b0;
    cyc(5);
    check_code("R3 transfer before proto", 8'h11);
    do_write(8'h22, 0);
    check("R4 violation flagged once", err_seen - e0, 1);
    check_code("R2 auto after proto", 8'h22);
    @(negedge clk) ldac_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_clr();
    do_write(8'h44, 0);
    check_code("R3 hold before clr", 8'h22);
    @(negedge clk) clr_n = 1'b0;
    #1;
    check("R5 async clear", code, 8'h00);
    cyc(3); clr_n = 1'b1; cyc(5);
    check_code("R5 stays clear", 8'h00);
    pulse_ldac();
    check_code("R5 stage intact", 8'h44);
  endtask

  task automatic t_clr_prio();
    do_write(8'h66, 0);
    check_code("R6 hold before", 8'h44);
    @(negedge clk) begin clr_n = 1'b0; ldac_n = 1'b0; end
    cyc(3);
    clr_n = 1'b1; ldac_n = 1'b1;
    cyc(5);
    check_code("R6 clear beats load", 8'h00);
    pulse_ldac();
    check_code("R6 stage intact", 8'h66);
  endtask

  task automatic t_pd();
    @(negedge clk) pd_n = 1'b0;
    cyc(5);
    check("R8 pd flag set", pwr_down, 1);
    check_code("R8 code kept in pd", 8'h66);
    do_write(8'h99, 0);
    pd_n = 1'b1;
    cyc(5);
    check("R8 pd flag clear", pwr_down, 0);
    check_code("R8 code kept after pd", 8'h66);
    pulse_ldac();
    check_code("R8 stage kept through pd", 8'h99);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ldac_n = 1'b1;
    clr_n = 1'b1; pd_n = 1'b1; din = 8'h00;
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_por();
    t_auto();
    t_therm();
    t_proto();
    t_clr();
    t_clr_prio();
    t_pd();
    cyc(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule